// File: doc/BRIEF.md
# SPI Slave Register-Access Controller

This block connects an SPI bus master to two banks of 8-bit registers. One bank holds read/write configuration registers, whose packed contents drive an output port. The other bank holds read-only status registers, whose packed contents are taken from an input port. The whole controller runs on the system clock. It synchronizes the select, serial clock and data-in lines, and it finds the serial clock edges by comparing successive synchronized samples.

Each transfer opens with a control byte and then an address byte. The control byte selects read or write, selects the bank, and can freeze the address pointer. Every group of eight serial clocks after the header moves one data byte to or from the register the pointer names. Unless the pointer is frozen, it then steps to the next register and wraps within the bank. Each kind of event raises its own one-cycle strobe. The serial data output comes with an enable that is high only while read data is being shifted out.

The clock polarity and phase are fixed by parameters. With polarity equal to phase, mosi is sampled on the rising sclk edge; otherwise it is sampled on the falling edge. Data changes on the opposite edge.

Top module: `spi_regif`

## Requirements
- R1: After reset, ctrl_o, addr_o and cfg_o are all zero, and miso_oe_o and all five strobes are low.
- R2: The first 8 bits after ss_ni falls are taken MSB first into ctrl_o, including user bits 7..3, and ctrl_wr_o pulses. ctrl_o changes only in a cycle where ctrl_wr_o is high.
- R3: The next 8 bits are taken MSB first into addr_o, and addr_wr_o pulses.
- R4: With control bit 0 = 0 (write) and bit 1 = 0 (config bank), each data byte is written into config register (pointer mod NUM_CFG), which is carried on cfg_o bits [8n+7:8n]. cfg_wr_o pulses for each byte, and cfg_o changes only in the cycle after a cfg_wr_o pulse.
- R5: After each data byte, the pointer becomes (index+1) mod bank size, with its upper bits cleared, unless control bit 2 = 1, in which case it is held.
- R6: A write with control bit 1 = 1 (status bank) leaves cfg_o unchanged and raises no cfg_wr_o.
- R7: A read (bit 0 = 1) of the config bank returns the addressed register on miso_o, MSB first, and cfg_rd_o pulses when each byte completes.
- R8: A read of the status bank returns the addressed byte of sts_i, and sts_rd_o pulses when each byte completes.
- R9: miso_oe_o is low during the header, during writes and while ss_ni is high. It is high while the data bits of a read are being shifted out.
- R10: Raising ss_ni in the middle of a byte discards the partial byte without any strobe. The next transfer starts again with a control byte.
- R11: Each strobe lasts one clock cycle, at most one strobe is high in any cycle, and every strobe matches a real event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for miso pad |
| ctrl_wr_o | output | 1 | Control byte captured strobe |
| addr_wr_o | output | 1 | Address byte captured strobe |
| cfg_wr_o | output | 1 | Config register written strobe |
| cfg_rd_o | output | 1 | Config register read strobe |
| sts_rd_o | output | 1 | Status register read strobe |
| ctrl_o | output | 8 | Current control byte |
| addr_o | output | 8 | Current address pointer |
| cfg_o | output | NUM_CFG*8 | Packed config registers |
| sts_i | input | NUM_STS*8 | Packed status registers |

## Verification
The assertions assume that the serial clock runs at no more than one sixth of the system clock, so that two sclk edges never fall within a single synchronizer latency. They also assume that mosi and ss_ni settle well before the sampling edge. Under these conditions the strobes stay one cycle wide and mutually exclusive. The bench acts as a mode (0,0) master with a half period of six system clocks. It changes mosi only after a shift edge and moves ss_ni only while sclk is idle. It also tries one aborted transfer with the clock low partway through a byte.

// File: rtl/spi_regif_pkg.sv
`timescale 1ns/1ps
package spi_regif_pkg;
  typedef enum logic [1:0] {PH_CTRL, PH_ADDR, PH_DATA} phase_e;
  // control byte fields decoded by the engine
  localparam int CB_RD   = 0;
  localparam int CB_STS  = 1;
  localparam int CB_HOLD = 2;
endpackage

// File: rtl/spi_regif_edge.sv
`timescale 1ns/1ps
module spi_regif_edge #(
  parameter int CPOL = 0,
  parameter int CPHA = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ss_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic act_o,
  output logic samp_o,
  output logic shft_o,
  output logic mosi_o
);
  localparam logic IDLE = 1'(CPOL);
  localparam bit SAMP_RISE = (CPOL == CPHA);

  logic [1:0] ss_q, sclk_q, mosi_q;
  logic sclk_d, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q   <= 2'b11;
      sclk_q <= {2{IDLE}};
      mosi_q <= 2'b00;
      sclk_d <= IDLE;
    end else begin
      ss_q   <= {ss_q[0], ss_ni};
      sclk_q <= {sclk_q[0], sclk_i};
      mosi_q <= {mosi_q[0], mosi_i};
      sclk_d <= sclk_q[1];
    end
  end

  assign act_o  = ~ss_q[1];
  assign mosi_o = mosi_q[1];
  assign rise   = act_o & sclk_q[1] & ~sclk_d;
  assign fall   = act_o & ~sclk_q[1] & sclk_d;

  generate
    if (SAMP_RISE) begin : g_samp_rise
      assign samp_o = rise;
      assign shft_o = fall;
    end else begin : g_samp_fall
      assign samp_o = fall;
      assign shft_o = rise;
    end
  endgenerate
endmodule

// File: rtl/spi_regif_fsm.sv
`timescale 1ns/1ps
module spi_regif_fsm
  import spi_regif_pkg::*;
#(
  parameter int CFG_AW = 2,
  parameter int STS_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              samp_i,
  input  logic              shft_i,
  input  logic              mosi_i,
  input  logic [7:0]        rd_byte_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        addr_o,
  output logic              ctrl_wr_o,
  output logic              addr_wr_o,
  output logic              cfg_we_o,
  output logic [7:0]        cfg_wdata_o,
  output logic [CFG_AW-1:0] cfg_widx_o,
  output logic              cfg_rd_o,
  output logic              sts_rd_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  phase_e     ph;
  logic [2:0] cnt;
  logic [7:0] rx, tx, ctrl_q, addr_q, addr_inc, byte_in;
  logic       tx_vld, miso_q;

  assign byte_in = {rx[6:0], mosi_i};

  always_comb begin
    addr_inc = '0;
    if (ctrl_q[CB_STS]) addr_inc[STS_AW-1:0] = addr_q[STS_AW-1:0] + 1'b1;
    else                addr_inc[CFG_AW-1:0] = addr_q[CFG_AW-1:0] + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph          <= PH_CTRL;
      cnt         <= '0;
      rx          <= '0;
      tx          <= '0;
      ctrl_q      <= '0;
      addr_q      <= '0;
      tx_vld      <= 1'b0;
      miso_q      <= 1'b0;
      ctrl_wr_o   <= 1'b0;
      addr_wr_o   <= 1'b0;
      cfg_we_o    <= 1'b0;
      cfg_wdata_o <= '0;
      cfg_widx_o  <= '0;
      cfg_rd_o    <= 1'b0;
      sts_rd_o    <= 1'b0;
    end else begin
      ctrl_wr_o <= 1'b0;
      addr_wr_o <= 1'b0;
      cfg_we_o  <= 1'b0;
      cfg_rd_o  <= 1'b0;
      sts_rd_o  <= 1'b0;
      if (!act_i) begin
        // deselect abandons any partial byte
        ph     <= PH_CTRL;
        cnt    <= '0;
        tx_vld <= 1'b0;
      end else begin
        if (samp_i) begin
          rx  <= byte_in;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            unique case (ph)
              PH_CTRL: begin
                ctrl_q    <= byte_in;
                ctrl_wr_o <= 1'b1;
                ph        <= PH_ADDR;
              end
              PH_ADDR: begin
                addr_q    <= byte_in;
                addr_wr_o <= 1'b1;
                ph        <= PH_DATA;
              end
              default: begin
                if (ctrl_q[CB_RD]) begin
                  if (ctrl_q[CB_STS]) sts_rd_o <= 1'b1;
                  else                cfg_rd_o <= 1'b1;
                end else if (!ctrl_q[CB_STS]) begin
                  cfg_we_o    <= 1'b1;
                  cfg_wdata_o <= byte_in;
                  cfg_widx_o  <= addr_q[CFG_AW-1:0];
                end
                if (!ctrl_q[CB_HOLD]) addr_q <= addr_inc;
              end
            endcase
          end
        end
        if (shft_i && ph == PH_DATA && ctrl_q[CB_RD]) begin
          if (cnt == 3'd0) begin
            // byte boundary: fetch the addressed register
            miso_q <= rd_byte_i[7];
            tx     <= {rd_byte_i[6:0], 1'b0};
            tx_vld <= 1'b1;
          end else begin
            miso_q <= tx[7];
            tx     <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign addr_o    = addr_q;
  assign miso_o    = miso_q;
  assign miso_oe_o = tx_vld;
endmodule

// File: rtl/spi_regif_cfg.sv
`timescale 1ns/1ps
module spi_regif_cfg #(
  parameter int NUM = 4,
  parameter int AW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  idx_i,
  input  logic [7:0]     wdata_i,
  output logic [NUM*8-1:0] regs_o
);
  for (genvar n = 0; n < NUM; n++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (we_i && idx_i == AW'(n))    q <= wdata_i;
    end
    assign regs_o[8*n +: 8] = q;
  end
endmodule

// File: rtl/spi_regif.sv
`timescale 1ns/1ps
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int NUM_STS = 4,
  parameter int CPOL    = 0,
  parameter int CPHA    = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               ss_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic               ctrl_wr_o,
  output logic               addr_wr_o,
  output logic               cfg_wr_o,
  output logic               cfg_rd_o,
  output logic               sts_rd_o,
  output logic [7:0]         ctrl_o,
  output logic [7:0]         addr_o,
  output logic [NUM_CFG*8-1:0] cfg_o,
  input  logic [NUM_STS*8-1:0] sts_i
);
  localparam int CFG_AW = $clog2(NUM_CFG);
  localparam int STS_AW = $clog2(NUM_STS);

  logic              act, samp, shft, mosi_s;
  logic              cfg_we;
  logic [7:0]        cfg_wdata, rd_byte;
  logic [CFG_AW-1:0] cfg_widx, cidx;
  logic [STS_AW-1:0] sidx;

  spi_regif_edge #(.CPOL(CPOL), .CPHA(CPHA)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ss_ni  (ss_ni),
    .sclk_i (sclk_i),
    .mosi_i (mosi_i),
    .act_o  (act),
    .samp_o (samp),
    .shft_o (shft),
    .mosi_o (mosi_s)
  );

  spi_regif_fsm #(.CFG_AW(CFG_AW), .STS_AW(STS_AW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .samp_i      (samp),
    .shft_i      (shft),
    .mosi_i      (mosi_s),
    .rd_byte_i   (rd_byte),
    .ctrl_o      (ctrl_o),
    .addr_o      (addr_o),
    .ctrl_wr_o   (ctrl_wr_o),
    .addr_wr_o   (addr_wr_o),
    .cfg_we_o    (cfg_we),
    .cfg_wdata_o (cfg_wdata),
    .cfg_widx_o  (cfg_widx),
    .cfg_rd_o    (cfg_rd_o),
    .sts_rd_o    (sts_rd_o),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o)
  );

  spi_regif_cfg #(.NUM(NUM_CFG), .AW(CFG_AW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we),
    .idx_i   (cfg_widx),
    .wdata_i (cfg_wdata),
    .regs_o  (cfg_o)
  );

  assign cidx = addr_o[CFG_AW-1:0];
  assign sidx = addr_o[STS_AW-1:0];
  assign rd_byte = ctrl_o[CB_STS] ? sts_i[{sidx, 3'b000} +: 8]
                                  : cfg_o[{cidx, 3'b000} +: 8];
  assign cfg_wr_o = cfg_we;
endmodule

// File: rtl/spi_regif_chk.sv
`timescale 1ns/1ps
module spi_regif_chk #(
  parameter int NUM_CFG = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               miso_oe_o,
  input logic               ctrl_wr_o,
  input logic               addr_wr_o,
  input logic               cfg_wr_o,
  input logic               cfg_rd_o,
  input logic               sts_rd_o,
  input logic [7:0]         ctrl_o,
  input logic [NUM_CFG*8-1:0] cfg_o
);
  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_wr_o, addr_wr_o, cfg_wr_o, cfg_rd_o, sts_rd_o}));

  assert_ctrl_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |=> !ctrl_wr_o);

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> ctrl_wr_o);

  assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(cfg_wr_o));

  assert_sts_nowrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> (!ctrl_o[1] && !ctrl_o[0]));

  assert_oe_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> ctrl_o[0]);
endmodule

bind spi_regif spi_regif_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .miso_oe_o (miso_oe_o),
  .ctrl_wr_o (ctrl_wr_o),
  .addr_wr_o (addr_wr_o),
  .cfg_wr_o  (cfg_wr_o),
  .cfg_rd_o  (cfg_rd_o),
  .sts_rd_o  (sts_rd_o),
  .ctrl_o    (ctrl_o),
  .cfg_o     (cfg_o)
);

// File: tb/spi_regif_bench.sv
`timescale 1ns/1ps
module spi_regif_bench;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int HALF = 6;
  localparam int K_CTRL = 0, K_ADDR = 1, K_CW = 2, K_CR = 3, K_SR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, ctrl_wr, addr_wr, cfg_wr, cfg_rd, sts_rd;
  logic [7:0] ctrl, addr;
  logic [NC*8-1:0] cfg;
  logic [NS*8-1:0] sts = 32'h330F_A511;

  int checks = 0, errors = 0;
  bit run = 1'b0, done = 1'b0;
  int exp_k[$];
  logic [7:0] exp_v[$];
  logic [7:0] tx_buf [0:7];
  logic [7:0] rx_buf [0:7];

  always #5 clk = ~clk;

  spi_regif u_spi_regif (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .ctrl_wr_o(ctrl_wr), .addr_wr_o(addr_wr),
    .cfg_wr_o(cfg_wr), .cfg_rd_o(cfg_rd), .sts_rd_o(sts_rd),
    .ctrl_o(ctrl), .addr_o(addr), .cfg_o(cfg), .sts_i(sts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int k, input logic [7:0] v);
    exp_k.push_back(k);
    exp_v.push_back(v);
  endtask

  // mode (0,0) master: n bytes from tx_buf, read bytes into rx_buf
  task automatic xfer(input int n, input bit rd);
    ss_n = 1'b0;
    tick(HALF);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx_buf[b][i];
        tick(HALF);
        rx_buf[b][i] = miso;
        chk("R9", {31'd0, miso_oe}, {31'd0, (b >= 2) && rd});
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
      end
    end
    tick(HALF);
    ss_n = 1'b1;
    tick(4 * HALF);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (run && rst_n && (ctrl_wr | addr_wr | cfg_wr | cfg_rd | sts_rd)) begin
      int k;
      chk("R11", {29'd0, 3'($countones({ctrl_wr, addr_wr, cfg_wr, cfg_rd, sts_rd}))}, 32'd1);
      k = ctrl_wr ? K_CTRL : addr_wr ? K_ADDR : cfg_wr ? K_CW : cfg_rd ? K_CR : K_SR;
      if (exp_k.size() == 0) begin
        chk("R11", k, 32'hFFFF_FFFF);
      end else begin
        int ek;
        logic [7:0] ev;
        ek = exp_k.pop_front();
        ev = exp_v.pop_front();
        chk(k == K_CTRL ? "R2" : k == K_ADDR ? "R3" : k == K_CW ? "R4" : k == K_CR ? "R7" : "R8", k, ek);
        if (k == ek && k == K_CTRL) chk("R2", {24'd0, ctrl}, {24'd0, ev});
        if (k == ek && k == K_ADDR) chk("R3", {24'd0, addr}, {24'd0, ev});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    // R1 reset state
    chk("R1", {24'd0, ctrl}, 32'd0);
    chk("R1", {24'd0, addr}, 32'd0);
    chk("R1", cfg, 32'd0);
    chk("R1", {27'd0, miso_oe, ctrl_wr, addr_wr, cfg_wr, cfg_rd | sts_rd}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    run = 1'b1;

    // R4 config write, auto-increment 2 -> 3 -> wraps to 0 (R5)
    tx_buf[0] = 8'h58; tx_buf[1] = 8'h02; tx_buf[2] = 8'h55; tx_buf[3] = 8'hAA;
    push(K_CTRL, 8'h58); push(K_ADDR, 8'h02); push(K_CW, 0); push(K_CW, 0);
    xfer(4, 1'b0);
    chk("R4", cfg, 32'hAA55_0000);
    chk("R2", {24'd0, ctrl}, 32'h58);
    chk("R5", {24'd0, addr}, 32'h00);

    // R7 config read, third byte wraps to reg 0
    tx_buf[0] = 8'h59; tx_buf[1] = 8'h02; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00; tx_buf[4] = 8'h00;
    push(K_CTRL, 8'h59); push(K_ADDR, 8'h02); push(K_CR, 0); push(K_CR, 0); push(K_CR, 0);
    xfer(5, 1'b1);
    chk("R7", {24'd0, rx_buf[2]}, 32'h55);
    chk("R7", {24'd0, rx_buf[3]}, 32'hAA);
    chk("R5", {24'd0, rx_buf[4]}, 32'h00);

    // R5 hold pointer: two writes to reg 1
    tx_buf[0] = 8'h04; tx_buf[1] = 8'h01; tx_buf[2] = 8'h11; tx_buf[3] = 8'h22;
    push(K_CTRL, 8'h04); push(K_ADDR, 8'h01); push(K_CW, 0); push(K_CW, 0);
    xfer(4, 1'b0);
    chk("R5", cfg, 32'hAA55_2200);
    chk("R5", {24'd0, addr}, 32'h01);

    // R6 write to status bank is a dummy
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h00; tx_buf[2] = 8'hFF; tx_buf[3] = 8'hEE;
    push(K_CTRL, 8'h02); push(K_ADDR, 8'h00);
    xfer(4, 1'b0);
    chk("R6", cfg, 32'hAA55_2200);

    // R8 status read from index 1 with wrap
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h01;
    for (int j = 2; j < 6; j++) tx_buf[j] = 8'h00;
    push(K_CTRL, 8'h03); push(K_ADDR, 8'h01);
    for (int j = 0; j < 4; j++) push(K_SR, 0);
    xfer(6, 1'b1);
    chk("R8", {24'd0, rx_buf[2]}, 32'hA5);
    chk("R8", {24'd0, rx_buf[3]}, 32'h0F);
    chk("R8", {24'd0, rx_buf[4]}, 32'h33);
    chk("R8", {24'd0, rx_buf[5]}, 32'h11);
    chk("R9", {31'd0, miso_oe}, 32'd0);

    // R10 aborted partial byte, then a fresh transfer
    ss_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
    tick(HALF);
    ss_n = 1'b1;
    tick(4 * HALF);
    chk("R10", {24'd0, ctrl}, 32'h03);
    tx_buf[0] = 8'h05; tx_buf[1] = 8'h03; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    push(K_CTRL, 8'h05); push(K_ADDR, 8'h03); push(K_CR, 0); push(K_CR, 0);
    xfer(4, 1'b1);
    chk("R10", {24'd0, ctrl}, 32'h05);
    chk("R10", {rx_buf[2], rx_buf[3]}, 32'hAAAA);

    tick(10);
    chk("R11", exp_k.size(), 32'd0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule